// File: doc/BRIEF.md
# Dual-Channel Output Compare Timer

The block runs a 16-bit counter and checks it against two compare channels. The counter advances once every 2, 4 or 8 system clocks, set by a prescaler select field. Each channel holds a 16-bit compare value. When the counter reaches that value on a tick, the channel sets its match flag. It also copies a programmed level into its output latch. If that channel's output enable is set, the latch drives the channel's pin. The interrupt line is raised while any match flag is set, but only if interrupts are enabled and the external mask input is low.

Software reaches the block through a byte-wide register bus with combinational read data. A compare value is written as two bytes. Writing the upper byte suspends comparison on that channel. Writing the lower byte turns comparison back on. This lets software retarget a channel without a false match midway through the update. A match flag clears only through a fixed two-step handshake: a status read that sees the flag set, then an access to that channel's lower compare byte.

Top module: `ocu_top`

## Requirements
- R1: After reset both compare values read 8000h (upper byte 80h, lower byte 00h), the status byte reads 00h, both pins are low and the interrupt is low.
- R2: Register addresses are as follows. Address 0 holds interrupt enable in bit 7 and the levels for channel 0/1 in bits 0/1. Address 1 holds the output enables for channel 0/1 in bits 0/1 and the prescaler select in bits 3:2. Address 2 is status, with channel 0/1 flags in bits 0/1. Addresses 3/4 are the upper/lower bytes of channel 0, and 5/6 the same for channel 1. Unused control bits read 0.
- R3: Prescaler select 00 advances the counter every 4 clocks, 01 every 2 clocks, and 10 or 11 every 8 clocks.
- R4: When the counter equals a channel's compare value on a tick, that channel's status flag becomes set.
- R5: On a match the channel's output latch takes its level bit. The pin shows the latch while the channel's output enable is 1, and is 0 otherwise.
- R6: The interrupt is high exactly when interrupt enable is 1, the mask input is 0, and at least one flag is set.
- R7: A flag clears only on an access (read or write) to that channel's lower byte that follows a status read which saw the flag set. A lower-byte access without that prior read, or an access to the other channel, leaves the flag set.
- R8: A write to a channel's upper byte stops that channel from matching until its lower byte is written. The other channel keeps matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register byte address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the cycle rdEn is high |
| irqMask | input | 1 | Global interrupt mask, 1 blocks the interrupt |
| cmpOut | output | 2 | Compare output pins, bit i for channel i |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that reads and writes are never issued in the same cycle and that each access lasts one clock. They also assume that a pin changes only after a match or a control write. The bench keeps to these assumptions: each of its bus tasks drives one strobe for exactly one cycle, with idle cycles between accesses. It also checks pin timing through the pins themselves and never alters control registers while waiting for a match edge.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  localparam int CH_NUM = 2;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int DIV_W  = 3;
  localparam int SEL_W  = 2;

  localparam logic [CNT_W-1:0]  CMP_RST  = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] ADR_CTLA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_CTLB = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(2);
  localparam int ADR_CMP_BASE = 3;

  typedef struct packed {
    logic [CH_NUM-1:0] wrHi;
    logic [CH_NUM-1:0] wrLo;
    logic [BYTE_W-1:0] data;
    logic [SEL_W-1:0]  prescSel;
  } ocuStrb_t;

  function automatic logic [ADDR_W-1:0] hiAddr(input int ch);
    return ADDR_W'(ADR_CMP_BASE + 2 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] loAddr(input int ch);
    return ADDR_W'(ADR_CMP_BASE + 2 * ch + 1);
  endfunction

  // terminal value of the divider: ticks every (limit+1) clocks
  function automatic logic [DIV_W-1:0] divLimit(input logic [SEL_W-1:0] sel);
    case (sel)
      2'b00:   return DIV_W'(3);
      2'b01:   return DIV_W'(1);
      default: return DIV_W'(7);
    endcase
  endfunction
endpackage

// File: rtl/ocu_dp.sv
module ocu_dp
  import ocu_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  ocuStrb_t                       strb,
  output logic [CH_NUM-1:0][CNT_W-1:0]   cmpVal,
  output logic [CH_NUM-1:0]              matchHit
);
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] freeCnt;
  logic             tick;

  assign tick = (divCnt >= divLimit(strb.prescSel));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      freeCnt <= '0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) freeCnt <= freeCnt + 1'b1;
    end
  end

  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_ch
    logic [CNT_W-1:0] cmpReg;
    logic             inhibit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpReg  <= CMP_RST;
        inhibit <= 1'b0;
      end else begin
        if (strb.wrHi[ch]) begin
          cmpReg[CNT_W-1:BYTE_W] <= strb.data;
          inhibit                <= 1'b1;
        end else if (strb.wrLo[ch]) begin
          cmpReg[BYTE_W-1:0] <= strb.data;
          inhibit            <= 1'b0;
        end
      end
    end

    assign cmpVal[ch]   = cmpReg;
    assign matchHit[ch] = tick && !inhibit && (freeCnt == cmpReg);
  end
endmodule

// File: rtl/ocu_ctrl.sv
module ocu_ctrl
  import ocu_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           wrEn,
  input  logic                           rdEn,
  input  logic [BYTE_W-1:0]              wrData,
  input  logic                           irqMask,
  input  logic [CH_NUM-1:0]              matchHit,
  input  logic [CH_NUM-1:0][CNT_W-1:0]   cmpVal,
  output ocuStrb_t                       strb,
  output logic [BYTE_W-1:0]              rdData,
  output logic [CH_NUM-1:0]              cmpOut,
  output logic [CH_NUM-1:0]              flags,
  output logic                           irq
);
  logic              irqEn;
  logic [CH_NUM-1:0] levelCfg;
  logic [CH_NUM-1:0] oeCfg;
  logic [SEL_W-1:0]  prescCfg;
  logic [CH_NUM-1:0] armed;
  logic [CH_NUM-1:0] outLatch;
  logic              statRd;
  logic [BYTE_W-1:0] rdMux;

  assign statRd = rdEn && (addr == ADR_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn    <= 1'b0;
      levelCfg <= '0;
      oeCfg    <= '0;
      prescCfg <= '0;
    end else if (wrEn) begin
      if (addr == ADR_CTLA) begin
        irqEn    <= wrData[BYTE_W-1];
        levelCfg <= wrData[CH_NUM-1:0];
      end
      if (addr == ADR_CTLB) begin
        oeCfg    <= wrData[CH_NUM-1:0];
        prescCfg <= wrData[CH_NUM+SEL_W-1:CH_NUM];
      end
    end
  end

  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_ch
    logic loAcc;
    assign loAcc = (wrEn || rdEn) && (addr == loAddr(ch));
    assign strb.wrHi[ch] = wrEn && (addr == hiAddr(ch));
    assign strb.wrLo[ch] = wrEn && (addr == loAddr(ch));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flags[ch]    <= 1'b0;
        armed[ch]    <= 1'b0;
        outLatch[ch] <= 1'b0;
      end else begin
        if (matchHit[ch]) flags[ch] <= 1'b1;
        else if (loAcc && armed[ch]) flags[ch] <= 1'b0;

        if (statRd && flags[ch]) armed[ch] <= 1'b1;
        else if (loAcc) armed[ch] <= 1'b0;

        if (matchHit[ch]) outLatch[ch] <= levelCfg[ch];
      end
    end
  end

  assign strb.data     = wrData;
  assign strb.prescSel = prescCfg;
  assign cmpOut        = outLatch & oeCfg;
  assign irq           = irqEn && !irqMask && (|flags);

  always_comb begin
    rdMux = '0;
    case (addr)
      ADR_CTLA: rdMux = {irqEn, {(BYTE_W-CH_NUM-1){1'b0}}, levelCfg};
      ADR_CTLB: rdMux = {{(BYTE_W-CH_NUM-SEL_W){1'b0}}, prescCfg, oeCfg};
      ADR_STAT: rdMux = {{(BYTE_W-CH_NUM){1'b0}}, flags};
      default: begin
        for (int ch = 0; ch < CH_NUM; ch++) begin
          if (addr == hiAddr(ch)) rdMux = cmpVal[ch][CNT_W-1:BYTE_W];
          if (addr == loAddr(ch)) rdMux = cmpVal[ch][BYTE_W-1:0];
        end
      end
    endcase
  end

  assign rdData = rdEn ? rdMux : '0;
endmodule

// File: rtl/ocu_top.sv
module ocu_top
  import ocu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              irqMask,
  output logic [1:0]        cmpOut,
  output logic              irq
);
  ocuStrb_t                      strb;
  logic [CH_NUM-1:0][CNT_W-1:0]  cmpVal;
  logic [CH_NUM-1:0]             matchHit;
  logic [CH_NUM-1:0]             flags;

  ocu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .irqMask(irqMask), .matchHit(matchHit), .cmpVal(cmpVal),
    .strb(strb), .rdData(rdData), .cmpOut(cmpOut), .flags(flags), .irq(irq)
  );

  ocu_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpVal(cmpVal), .matchHit(matchHit)
  );
endmodule

// File: rtl/ocu_chk.sv
module ocu_chk
  import ocu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic              irqMask,
  input logic              irq,
  input logic [1:0]        cmpOut,
  input logic [1:0]        matchHit,
  input logic [1:0]        flags
);
  // R6
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqMask |-> !irq);
  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flags != 2'b00));

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    // R4
    flag_set_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flags[ch]) |-> $past(matchHit[ch]));
    // R7
    flag_clr_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flags[ch]) |-> $past((wrEn || rdEn) && addr == loAddr(ch)));
    // R8
    hi_write_inhibit_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == hiAddr(ch)) |=> !matchHit[ch]);
    // R5
    pin_change_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(cmpOut[ch]) |-> $past(matchHit[ch] || (wrEn && addr == ADR_CTLB)));
  end
endmodule

bind ocu_top ocu_chk u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .irqMask(irqMask), .irq(irq), .cmpOut(cmpOut), .matchHit(matchHit),
  .flags(flags)
);

// File: tb/ocu_top_bench.sv
module ocu_top_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irqMask = 1'b0;
  logic [1:0] cmpOut;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit reported = 1'b0;

  ocu_top u_ocu_top (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irqMask(irqMask), .cmpOut(cmpOut), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; irqMask = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pollFlag(input int bitIdx, output bit seen);
    logic [7:0] s;
    seen = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      rd(3'd2, s);
      seen = s[bitIdx];
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    doReset();
    rd(3'd3, d); chk(d == 8'h80, "R1 ch0 upper", d, 8'h80);
    rd(3'd4, d); chk(d == 8'h00, "R1 ch0 lower", d, 8'h00);
    rd(3'd5, d); chk(d == 8'h80, "R1 ch1 upper", d, 8'h80);
    rd(3'd6, d); chk(d == 8'h00, "R1 ch1 lower", d, 8'h00);
    rd(3'd2, d); chk(d == 8'h00, "R1 status", d, 8'h00);
    chk(cmpOut == 2'b00, "R1 pins", cmpOut, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    doReset();
    wr(3'd0, 8'hFF); rd(3'd0, d); chk(d == 8'h83, "R2 ctrl A readback", d, 8'h83);
    wr(3'd1, 8'hFF); rd(3'd1, d); chk(d == 8'h0F, "R2 ctrl B readback", d, 8'h0F);
    wr(3'd5, 8'h12); wr(3'd6, 8'h34);
    rd(3'd5, d); chk(d == 8'h12, "R2 ch1 upper", d, 8'h12);
    rd(3'd6, d); chk(d == 8'h34, "R2 ch1 lower", d, 8'h34);
  endtask

  task automatic t_presc(input logic [1:0] sel, input int div);
    time t0, t1;
    logic [7:0] d;
    doReset();
    wr(3'd0, 8'h03);
    wr(3'd1, {4'h0, sel, 2'b11});
    wr(3'd3, 8'h00); wr(3'd4, 8'h40);
    wr(3'd5, 8'h00); wr(3'd6, 8'h4A);
    wait (cmpOut[0]); t0 = $time;
    wait (cmpOut[1]); t1 = $time;
    chk((t1 - t0) == 10 * div * CLK_PERIOD, "R3 tick spacing",
        int'((t1 - t0) / CLK_PERIOD), 10 * div);
    rd(3'd2, d); chk(d[1:0] == 2'b11, "R4 both flags set", d, 3);
  endtask

  task automatic t_pin();
    bit seen;
    doReset();
    wr(3'd1, 8'h04);
    wr(3'd0, 8'h01);
    wr(3'd3, 8'h00); wr(3'd4, 8'h30);
    pollFlag(0, seen);
    chk(seen, "R4 flag0 set", seen, 1);
    chk(cmpOut[0] == 1'b0, "R5 pin gated by enable", cmpOut[0], 0);
    wr(3'd1, 8'h05);
    #1 chk(cmpOut[0] == 1'b1, "R5 pin shows latched level", cmpOut[0], 1);
    chk(cmpOut[1] == 1'b0, "R5 ch1 pin idle", cmpOut[1], 0);
  endtask

  task automatic t_irq();
    bit seen;
    doReset();
    irqMask = 1'b1;
    wr(3'd1, 8'h04);
    wr(3'd0, 8'h80);
    wr(3'd3, 8'h00); wr(3'd4, 8'h30);
    pollFlag(0, seen);
    chk(irq == 1'b0, "R6 irq masked", irq, 0);
    @(negedge clk); irqMask = 1'b0; #1;
    chk(irq == 1'b1, "R6 irq unmasked", irq, 1);
    wr(3'd0, 8'h00); #1;
    chk(irq == 1'b0, "R6 irq disabled", irq, 0);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    doReset();
    wr(3'd1, 8'h04);
    wr(3'd0, 8'h80);
    wr(3'd3, 8'h00); wr(3'd4, 8'h20);
    wait (irq);
    rd(3'd4, d);
    rd(3'd2, d); chk(d[0] == 1'b1, "R7 lower access without status read", d, 1);
    rd(3'd6, d);
    rd(3'd2, d); chk(d[0] == 1'b1, "R7 other channel access", d, 1);
    wr(3'd4, 8'h20);
    rd(3'd2, d); chk(d[0] == 1'b0, "R7 flag cleared by sequence", d, 0);
    chk(irq == 1'b0, "R7 irq dropped", irq, 0);
  endtask

  task automatic t_inhibit();
    logic [7:0] d;
    bit seen;
    doReset();
    wr(3'd1, 8'h04);
    wr(3'd4, 8'h40);
    wr(3'd3, 8'h00);
    wr(3'd5, 8'h00); wr(3'd6, 8'h40);
    repeat (300) @(negedge clk);
    rd(3'd2, d);
    chk(d[0] == 1'b0, "R8 upper write inhibits ch0", d, 0);
    chk(d[1] == 1'b1, "R8 ch1 still matches", d, 1);
    wr(3'd4, 8'hA0);
    pollFlag(0, seen);
    chk(seen, "R8 lower write re-enables ch0", seen, 1);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    t_reset();
    t_regs();
    t_presc(2'b00, 4);
    t_presc(2'b01, 2);
    t_presc(2'b10, 8);
    t_presc(2'b11, 8);
    t_pin();
    t_irq();
    t_clear();
    t_inhibit();
    summary();
  end
endmodule